// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the I2C slave side of an 8 KB byte-addressed non-volatile store, built around an internal synthesizable byte array. It samples the bus clock and data lines on a faster system clock and detects START and STOP conditions. It answers only device-select bytes whose family code and three strap bits match its own. After a write select, two address bytes load an auto-incrementing location counter. Each later byte is stored at the counter, and the counter then moves to the next location. After a read select, the block shifts bytes out from the counter, and the master's acknowledge decides whether the read goes on.

A write-protect input guards the array. A parameter picks one of two protect variants. In the first, the pin freezes the whole array. In the second, it freezes only the upper quarter. The data line is never driven high. The block puts out a single drive-low enable for an external open-drain pad. Several copies with different straps can share one bus.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: `sda_oe` is a drive-low enable only (1 pulls SDA low, 0 releases it). It is 0 after reset, and 0 whenever the block is not addressed.
- R2: A START (SDA falling while SCL is high) at any point restarts reception of a device-select byte. A STOP (SDA rising while SCL is high) at any point returns the block to idle and releases SDA, even in the middle of a byte.
- R3: The device-select byte is sent MSB first as 1010, then A2 A1 A0, then R/W in bit 0 (0 = write, 1 = read). The block acknowledges it by pulling SDA low for the whole ninth SCL high phase, and only when the code is 1010 and A2..A0 equal `strap_i`. On a mismatch it gives no ACK and ignores the bus until the next START.
- R4: After a write select, a high address byte and then a low address byte load the 13-bit counter. The top three bits of the high byte are ignored. Each address byte is acknowledged.
- R5: Each data byte after the low address byte is acknowledged, stored at the counter unless protected, and followed by a counter increment.
- R6: The counter wraps from 1FFFh to 0000h, for writes and for reads alike.
- R7: After a read select, bytes come from the counter MSB first. The block holds each bit on SDA for the whole SCL high phase and adds one to the counter after each byte. A master ACK (SDA low in the ninth clock) continues the read. A master NACK releases SDA and leaves the block idle until the next START.
- R8: A random read works as follows: a write select plus two address bytes, then a repeated START and a read select, return data from the newly loaded address.
- R9: With `WP_QUARTER` = 0 and `wp_i` high, no data byte is stored at any address. The data bytes are still acknowledged.
- R10: With `WP_QUARTER` = 1 and `wp_i` high, bytes aimed at 1800h–1FFFh are not stored, while bytes aimed below 1800h are stored.
- R11: With `wp_i` low, writes succeed at every address in both variants.
- R12: `sda_oe` changes only after a detected SCL falling edge, START or STOP, and never during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_oe | output | 1 | Open-drain pull-low enable for SDA |
| strap_i | input | 3 | Device address straps A2..A0 |
| wp_i | input | 1 | Write-protect input, active high |

## Verification
The assertions watch these rules on every cycle:
- the line is released when the block is idle;
- a STOP forces idle, and a START forces select reception;
- an ACK to a select byte goes out only on a matching address;
- a store is always followed by an advanced counter;
- no store reaches a region that the protect pin covers;
- the drive enable changes only after an SCL fall, a START or a STOP.

Other behaviour only the bench's bus transactions can show:
- the correct data comes back after byte, sequential and random reads;
- the counter wraps at the top of the array;
- the high address bits are ignored;
- the two protect variants do what they should;
- the block recovers after transfers aborted mid-byte.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } slv_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  localparam logic [3:0] BIT_BYTE_DONE = 4'd8;
  localparam logic [3:0] BIT_ACK_DONE  = 4'd9;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_ff;
  logic [TOP:0] sda_ff;
  logic         scl_d;
  logic         sda_d;
  logic         scl_s;

  // bus idles high, so every stage resets to 1
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[TOP-1:0], scl_i};
      sda_ff <= {sda_ff[TOP-1:0], sda_i};
      scl_d  <= scl_ff[TOP];
      sda_d  <= sda_ff[TOP];
    end
  end

  assign scl_s     = scl_ff[TOP];
  assign sda_s     = sda_ff[TOP];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_wp_guard.sv
module i2c_wp_guard #(
  parameter int AW         = 13,
  parameter bit WP_QUARTER = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic          wp,
  output logic          blocked
);

  generate
    if (WP_QUARTER) begin : g_quarter
      assign blocked = wp & (&addr[AW-1:AW-2]);
    end else begin : g_full
      logic unused_addr;
      assign unused_addr = ^addr;
      assign blocked     = wp;
    end
  endgenerate

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // one write port, one registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_eeprom_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [2:0]    strap_i,
  input  logic [7:0]    rd_byte,
  input  logic          wr_blocked,
  output logic          sda_oe,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] cur_addr
);

  localparam int HI_W = AW - 8;

  slv_state_e state;
  logic [3:0] bitcnt;
  logic [7:0] rx_sh;
  logic [6:0] tx_sh;
  logic       rw_bit;
  logic       m_nack;
  logic       sel_hit;

  assign sel_hit = (rx_sh[7:4] == DEV_CODE) && (rx_sh[3:1] == strap_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rw_bit    <= 1'b0;
      m_nack    <= 1'b1;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      cur_addr  <= '0;
    end else begin
      mem_we <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
        // bits are taken on rising SCL
        if (scl_rise) begin
          if (bitcnt < BIT_BYTE_DONE) begin
            rx_sh  <= {rx_sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == BIT_BYTE_DONE) begin
            m_nack <= sda_s;
            bitcnt <= BIT_ACK_DONE;
          end
        end
        // the line is changed only on falling SCL
        if (scl_fall) begin
          if (bitcnt == BIT_BYTE_DONE) begin
            case (state)
              ST_DEV: begin
                if (sel_hit) begin
                  sda_oe <= 1'b1;
                  rw_bit <= rx_sh[0];
                end else begin
                  state  <= ST_IDLE;
                  bitcnt <= '0;
                end
              end
              ST_AHI: begin
                sda_oe             <= 1'b1;
                cur_addr[AW-1:8]   <= rx_sh[HI_W-1:0];
              end
              ST_ALO: begin
                sda_oe        <= 1'b1;
                cur_addr[7:0] <= rx_sh;
              end
              ST_WR: begin
                sda_oe    <= 1'b1;
                mem_we    <= ~wr_blocked;
                mem_waddr <= cur_addr;
                mem_wdata <= rx_sh;
                cur_addr  <= cur_addr + 1'b1;
              end
              ST_RD: begin
                sda_oe   <= 1'b0;
                cur_addr <= cur_addr + 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitcnt == BIT_ACK_DONE) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (state)
              ST_DEV: begin
                if (rw_bit) begin
                  state  <= ST_RD;
                  tx_sh  <= rd_byte[6:0];
                  sda_oe <= ~rd_byte[7];
                end else begin
                  state <= ST_AHI;
                end
              end
              ST_AHI: state <= ST_ALO;
              ST_ALO: state <= ST_WR;
              ST_RD: begin
                if (m_nack) begin
                  state <= ST_IDLE;
                end else begin
                  tx_sh  <= rd_byte[6:0];
                  sda_oe <= ~rd_byte[7];
                end
              end
              default: state <= state;
            endcase
          end else if ((bitcnt != 4'd0) && (state == ST_RD)) begin
            sda_oe <= ~tx_sh[6];
            tx_sh  <= {tx_sh[5:0], 1'b0};
          end
        end
      end
    end
  end

  // R1: an idle block leaves the line released
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R2: STOP always ends in idle with the line free
  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE) && !sda_oe);

  // R2: START always restarts select reception from bit zero
  assert_start_select_R2: assert property (@(posedge clk) disable iff (rst)
    (start_det && !stop_det) |=> (state == ST_DEV) && (bitcnt == 4'd0));

  // R3: an ACK in the select phase implies a matching address byte
  assert_ack_match_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEV && sda_oe) |-> (rx_sh[7:4] == DEV_CODE) && (rx_sh[3:1] == strap_i));

  // R5: every store leaves the counter one past the stored location
  assert_write_advance_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (cur_addr == AW'(mem_waddr + 1'b1)));

  // R12: drive changes follow only SCL falls or bus conditions
  assert_drive_after_fall_R12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // bit counter stays inside one byte plus its ACK slot
  assert_bitcnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= BIT_ACK_DONE);

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int AW          = 13,
  parameter bit WP_QUARTER  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);

  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          sda_s;
  logic          wr_blocked;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic [AW-1:0] cur_addr;
  logic [7:0]    rd_byte;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s)
  );

  i2c_wp_guard #(.AW(AW), .WP_QUARTER(WP_QUARTER)) u_guard (
    .addr    (cur_addr),
    .wp      (wp_i),
    .blocked (wr_blocked)
  );

  i2c_slave_fsm #(.AW(AW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_s      (sda_s),
    .strap_i    (strap_i),
    .rd_byte    (rd_byte),
    .wr_blocked (wr_blocked),
    .sda_oe     (sda_oe),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .cur_addr   (cur_addr)
  );

  eeprom_array #(.AW(AW), .DW(8)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (cur_addr),
    .rdata (rd_byte)
  );

  generate
    if (WP_QUARTER) begin : g_chk_quarter
      // R10: no store lands in the top quarter while protected
      assert_wp_quarter_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_we && wp_i) |-> !(&mem_waddr[AW-1:AW-2]));
    end else begin : g_chk_full
      // R9: no store at all while protected
      assert_wp_full_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !wp_i);
    end
  endgenerate

endmodule

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic scl_drv = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic oe_a, oe_b;
  logic sda_line;
  assign sda_line = m_sda & ~oe_a & ~oe_b;

  // device 0: quarter protect, straps 101; device 1: full protect, straps 010
  i2c_eeprom_slave #(.WP_QUARTER(1'b1)) i_i2c_eeprom_slave (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe(oe_a), .strap_i(3'b101), .wp_i(wp));

  i2c_eeprom_slave #(.WP_QUARTER(1'b0)) i_i2c_eeprom_slave_full (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe(oe_b), .strap_i(3'b010), .wp_i(wp));

  int checks = 0;
  int fails  = 0;
  logic exp_a = 1'b0, exp_b = 1'b0, cmp_en = 1'b0;
  string cmp_tag = "R12";

  logic [2:0] strp [2] = '{3'b101, 3'b010};
  bit quarter [2] = '{1'b1, 1'b0};
  logic [7:0] mdl_mem [int];
  int mdl_addr [2] = '{0, 0};
  int mdl_st [2] = '{0, 0};   // 0 idle 1 select 2 hi 3 lo 4 write 5 read
  logic [7:0] wq [$];

  // clock-by-clock comparison of both drive enables during SCL high
  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (oe_a !== exp_a) begin
        fails++;
        $display("FAIL %s dev0 drive actual=%0b expected=%0b", cmp_tag, oe_a, exp_a);
      end
      checks++;
      if (oe_b !== exp_b) begin
        fails++;
        $display("FAIL %s dev1 drive actual=%0b expected=%0b", cmp_tag, oe_b, exp_b);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int key(input int d, input int a);
    return d * 8192 + a;
  endfunction

  function automatic bit is_blocked(input int d, input int a);
    if (!wp) return 1'b0;
    if (quarter[d]) return a >= 'h1800;
    return 1'b1;
  endfunction

  task automatic clock_bit(input bit b, input bit ea, input bit eb, output bit seen);
    wait_clk(5);
    m_sda = b;
    wait_clk(15);
    exp_a = ea;
    exp_b = eb;
    scl_drv = 1'b1;
    wait_clk(2);
    cmp_en = 1'b1;
    wait_clk(8);
    seen = sda_line;
    wait_clk(8);
    cmp_en = 1'b0;
    wait_clk(2);
    scl_drv = 1'b0;
  endtask

  task automatic do_start();
    wait_clk(5);
    m_sda = 1'b1;
    wait_clk(15);
    scl_drv = 1'b1;
    wait_clk(10);
    m_sda = 1'b0;
    wait_clk(10);
    scl_drv = 1'b0;
    for (int d = 0; d < 2; d++) mdl_st[d] = 1;
  endtask

  task automatic do_stop();
    wait_clk(5);
    m_sda = 1'b0;
    wait_clk(15);
    scl_drv = 1'b1;
    wait_clk(10);
    m_sda = 1'b1;
    wait_clk(20);
    for (int d = 0; d < 2; d++) mdl_st[d] = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    bit ack [2];
    bit s;
    for (int d = 0; d < 2; d++) begin
      ack[d] = 1'b0;
      case (mdl_st[d])
        1: begin
          if (b[7:4] == 4'hA && b[3:1] == strp[d]) begin
            ack[d] = 1'b1;
            mdl_st[d] = b[0] ? 5 : 2;
          end else mdl_st[d] = 0;
        end
        2: begin ack[d] = 1'b1; mdl_addr[d] = (mdl_addr[d] & 'hFF) | ((b & 'h1F) << 8); mdl_st[d] = 3; end
        3: begin ack[d] = 1'b1; mdl_addr[d] = (mdl_addr[d] & 'h1F00) | b; mdl_st[d] = 4; end
        4: begin
          ack[d] = 1'b1;
          if (!is_blocked(d, mdl_addr[d])) mdl_mem[key(d, mdl_addr[d])] = b;
          mdl_addr[d] = (mdl_addr[d] + 1) & 'h1FFF;
        end
        default: ack[d] = 1'b0;
      endcase
    end
    cmp_tag = "R12";
    for (int i = 7; i >= 0; i--) clock_bit(b[i], 1'b0, 1'b0, s);
    cmp_tag = tag;
    clock_bit(1'b1, ack[0], ack[1], s);
    check(tag, s == !(ack[0] | ack[1]), s, !(ack[0] | ack[1]));
    cmp_tag = "R12";
  endtask

  task automatic read_byte(input bit last, input string tag);
    int rd;
    logic [7:0] want, got;
    bit s;
    rd = -1;
    for (int d = 0; d < 2; d++) if (mdl_st[d] == 5) rd = d;
    if (rd < 0) begin
      check(tag, 1'b0, 32'hFFFF_FFFF, 32'd0);
      return;
    end
    want = mdl_mem.exists(key(rd, mdl_addr[rd])) ? mdl_mem[key(rd, mdl_addr[rd])] : 8'h00;
    cmp_tag = tag;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, (rd == 0) ? ~want[i] : 1'b0, (rd == 1) ? ~want[i] : 1'b0, s);
      got[i] = s;
    end
    cmp_tag = "R7";
    clock_bit(last, 1'b0, 1'b0, s);
    check(tag, got === want, got, want);
    mdl_addr[rd] = (mdl_addr[rd] + 1) & 'h1FFF;
    if (last) mdl_st[rd] = 0;
    cmp_tag = "R12";
  endtask

  task automatic write_seq(input int d, input logic [7:0] hi, input logic [7:0] lo, input string tag);
    do_start();
    send_byte({4'hA, strp[d], 1'b0}, "R3");
    send_byte(hi, "R4");
    send_byte(lo, "R4");
    foreach (wq[i]) send_byte(wq[i], tag);
    do_stop();
  endtask

  task automatic read_seq(input int d, input logic [7:0] hi, input logic [7:0] lo, input int n, input string tag);
    do_start();
    send_byte({4'hA, strp[d], 1'b0}, "R8");
    send_byte(hi, "R4");
    send_byte(lo, "R4");
    do_start();
    send_byte({4'hA, strp[d], 1'b1}, "R8");
    for (int i = 0; i < n; i++) read_byte(i == n - 1, tag);
    do_stop();
  endtask

  initial begin
    bit s;
    wait_clk(6);
    rst = 1'b0;
    wait_clk(3);
    check("R1", oe_a == 1'b0, oe_a, 0);
    check("R1", oe_b == 1'b0, oe_b, 0);

    // R5: sequential write, then R8 random read back
    wq.delete(); wq.push_back(8'hA5); wq.push_back(8'h3C); wq.push_back(8'hFF); wq.push_back(8'h69);
    write_seq(0, 8'h01, 8'h23, "R5");
    read_seq(0, 8'h01, 8'h23, 3, "R8");

    // R7: current-address read continues at the counter (0126h)
    do_start();
    send_byte({4'hA, strp[0], 1'b1}, "R7");
    read_byte(1'b1, "R7");
    do_stop();

    // R3: wrong straps and wrong family code are not acknowledged
    do_start();
    send_byte({4'hA, 3'b111, 1'b0}, "R3");
    send_byte(8'h55, "R3");
    do_stop();
    do_start();
    send_byte({4'hB, 3'b101, 1'b0}, "R3");
    do_stop();
    check("R1", oe_a == 1'b0 && oe_b == 1'b0, {oe_a, oe_b}, 0);

    // R4/R6: high bits ignored (FFh -> 1Fh) and wrap past 1FFFh
    wq.delete(); wq.push_back(8'h81); wq.push_back(8'h82); wq.push_back(8'h83);
    write_seq(1, 8'hFF, 8'hFE, "R6");
    read_seq(1, 8'h1F, 8'hFE, 3, "R6");

    // R11: unprotected writes in both variants
    wq.delete(); wq.push_back(8'h11);
    write_seq(0, 8'h18, 8'h00, "R11");
    wq.delete(); wq.push_back(8'h22);
    write_seq(1, 8'h00, 8'h10, "R11");
    read_seq(0, 8'h18, 8'h00, 1, "R11");
    read_seq(1, 8'h00, 8'h10, 1, "R11");

    // R10: quarter protect keeps 1800h, stores 17FFh
    wp = 1'b1;
    wq.delete(); wq.push_back(8'h33); wq.push_back(8'h44);
    write_seq(0, 8'h17, 8'hFF, "R10");
    read_seq(0, 8'h17, 8'hFF, 2, "R10");

    // R9: full protect keeps 0010h, bytes still acknowledged
    wq.delete(); wq.push_back(8'h77);
    write_seq(1, 8'h00, 8'h10, "R9");
    read_seq(1, 8'h00, 8'h10, 1, "R9");
    wp = 1'b0;

    // R2: STOP in the middle of a select byte, then normal service
    do_start();
    for (int i = 7; i >= 4; i--) clock_bit(i[0], 1'b0, 1'b0, s);
    do_stop();
    check("R2", oe_a == 1'b0 && oe_b == 1'b0, {oe_a, oe_b}, 0);
    read_seq(0, 8'h01, 8'h24, 1, "R2");

    // R2: repeated START in the middle of an address byte
    do_start();
    send_byte({4'hA, strp[1], 1'b0}, "R2");
    for (int i = 0; i < 3; i++) clock_bit(1'b0, 1'b0, 1'b0, s);
    do_start();
    send_byte({4'hA, strp[1], 1'b0}, "R2");
    send_byte(8'h00, "R2");
    send_byte(8'h10, "R2");
    do_start();
    send_byte({4'hA, strp[1], 1'b1}, "R2");
    read_byte(1'b1, "R2");
    do_stop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule